// File: doc/BRIEF.md
# Legacy I/O configuration register controller

This block sits on a byte-wide legacy I/O bus and owns the configuration of a group of on-board peripherals: one parallel port, two serial ports, a floppy controller and an IDE controller. The host reaches it through a pair of byte ports at a fixed base address. The even address is an index port and the odd address is a data port. Three 8-bit configuration registers sit behind the data port: a function-enable register, an address-map register and a power/test register. A 5-bit strap value picks their reset contents from a built-in table.

From the three registers the block decodes, for every peripheral, an enable, an I/O base address and an IRQ number. These are held in registers and driven as outputs to the address decoders and interrupt routing of the rest of the chip. A one-cycle pulse marks each accepted configuration write. After reset, the first read of the index port returns an identification byte, so that software can detect the block.

Top module: `sio_cfg_ctrl`

## Requirements
- R1: On reset, the selected index becomes 0 and the three registers load from a 32-entry table indexed by `strap`. Strap 1 gives enable 0x4F, map 0x11 and power 0x00. Strap 31 gives 0x00, 0x10 and 0x02. `io_rdata` resets to 0x00.
- R2: A write to the index port (address bit 0 = 0) loads `io_wdata` into the selected index.
- R3: A write to the data port (address bit 0 = 1) stores `io_wdata` into the selected register: index 0 is enable, 1 is map, 2 is power. With any other index the write changes no register.
- R4: A data-port read puts the selected register on `io_rdata` on the clock edge that samples the read, or 0x00 when the index is 3 or higher. `io_rdata` holds its value between reads.
- R5: The first index-port read after reset returns the ID byte 0x88, and every later index-port read returns the selected index. Any accepted index-port write ends the ID phase.
- R6: An access is accepted only when `io_byte` is 1 and `io_addr[15:1]` equals the base address (default 0x398) shifted right by one. Any other access changes no state and no output. When `io_wr` and `io_rd` are both high, the write is taken.
- R7: The decoded enables follow the enable register: bit0 parallel, bit1 serial 0, bit2 serial 1, bit3 floppy, bit6 IDE.
- R8: The parallel select is map[1:0]. The values 0, 1, 2 and 3 give the bases 0x378, 0x3BC, 0x278 and 0x000. The IRQ is 7 for select 1, 5 for select 2 and 0 for select 3. For select 0 the IRQ is 7 when power bit3 is set, and 5 otherwise.
- R9: Serial port n uses the select s = map[2n+3:2n+2]. The value s = 0 gives 0x3F8 and s = 1 gives 0x2F8. When s is 2 or 3, map[7:6] picks a column from {0x3E8,0x338,0x2E8,0x220} (even s) or from {0x2E8,0x238,0x2E0,0x228} (odd s). The IRQ is 3 for odd s and 4 for even s. Port n's base is `uart_base[16n+15:16n]` and its IRQ is `uart_irq[4n+3:4n]`.
- R10: The floppy base is 0x370 when enable bit5 is set and 0x3F0 otherwise, with IRQ 6. The IDE base is 0x170 when enable bit7 is set and 0x1F0 otherwise. The IDE second base is the IDE base plus 0x206, and the IDE IRQ is 14.
- R11: `cfg_wr_pulse` is high for exactly the one cycle after each accepted data-port write to index 0, 1 or 2, and low at all other times.
- R12: The decoded outputs are registered. After a register write they change on the second clock edge (one edge after `cfg_wr_pulse` rises), and otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap | input | 5 | Selects the reset defaults |
| io_addr | input | 16 | Bus I/O address |
| io_byte | input | 1 | 1 when the access is byte-wide |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |
| cfg_wr_pulse | output | 1 | Configuration-changed pulse |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 16 | Parallel port base address |
| par_irq | output | 4 | Parallel port IRQ |
| uart_en | output | 2 | Serial port enables, bit n for port n |
| uart_base | output | 32 | Serial base addresses, 16 bits per port |
| uart_irq | output | 8 | Serial IRQs, 4 bits per port |
| fdc_en | output | 1 | Floppy enable |
| fdc_base | output | 16 | Floppy base address |
| fdc_irq | output | 4 | Floppy IRQ |
| ide_en | output | 1 | IDE enable |
| ide_base | output | 16 | IDE base address |
| ide_base2 | output | 16 | IDE second base address |
| ide_irq | output | 4 | IDE IRQ |

## Verification
The map register is swept through all 256 values, and two passes set and clear power bit3. This covers every parallel select and both IRQ choices for select 0. For each serial port it covers every select value in every 3/4 column, which separates the odd table row from the even one and shows that each port reads only its own bit pair. The enable register is also swept through all 256 values. Each bit is then seen driving only its own enable or alternate address. A reset under each of the 32 strap values, with a register read-back, checks the default table entry by entry. Directed sequences cover the ID byte, a data access to an index of 3 or higher, accesses at the wrong address or width, and the one-edge lag of the decoded outputs behind the write pulse.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam int IO_W     = 16;
    localparam int IRQ_W    = 4;
    localparam int STRAP_W  = 5;
    localparam int NUM_UART = 2;
    localparam int NUM_REGS = 3;

    typedef struct packed {
        logic [7:0] en;
        logic [7:0] map;
        logic [7:0] pwr;
    } cfg_regs_t;

    typedef struct packed {
        logic                      par_en;
        logic [IO_W-1:0]           par_base;
        logic [IRQ_W-1:0]          par_irq;
        logic [NUM_UART-1:0]       uart_en;
        logic [NUM_UART*IO_W-1:0]  uart_base;
        logic [NUM_UART*IRQ_W-1:0] uart_irq;
        logic                      fdc_en;
        logic [IO_W-1:0]           fdc_base;
        logic [IRQ_W-1:0]          fdc_irq;
        logic                      ide_en;
        logic [IO_W-1:0]           ide_base;
        logic [IO_W-1:0]           ide_base2;
        logic [IRQ_W-1:0]          ide_irq;
    } dec_t;

    function automatic logic [7:0] strap_en(input logic [STRAP_W-1:0] s);
        logic [7:0] v;
        if (s == 5'd31)      v = 8'h00;
        else if (s == 5'd30) v = 8'h08;
        else if (s >= 5'd24) v = 8'h47;
        else if (s >= 5'd20) v = 8'h07;
        else if (s >= 5'd16) v = 8'h49;
        else if (s >= 5'd12) v = 8'h0F;
        else if (s >= 5'd6)  v = 8'h4B;
        else                 v = 8'h4F;
        return v;
    endfunction

    function automatic logic [7:0] strap_map(input logic [STRAP_W-1:0] s);
        logic [7:0] v;
        case (s)
            5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31:     v = 8'h10;
            5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:      v = 8'h11;
            5'd3, 5'd14, 5'd22, 5'd27:                   v = 8'h39;
            5'd4, 5'd15, 5'd23, 5'd28:                   v = 8'h24;
            5'd5, 5'd29:                                 v = 8'h38;
            5'd7, 5'd8, 5'd17, 5'd18:                    v = 8'h01;
            5'd9:                                        v = 8'h09;
            5'd10, 5'd11:                                v = 8'h08;
            default:                                     v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic [7:0] strap_pwr(input logic [STRAP_W-1:0] s);
        return (s == 5'd31) ? 8'h02 : 8'h00;
    endfunction

    function automatic cfg_regs_t strap_defaults(input logic [STRAP_W-1:0] s);
        cfg_regs_t r;
        r.en  = strap_en(s);
        r.map = strap_map(s);
        r.pwr = strap_pwr(s);
        return r;
    endfunction

    // serial base: fixed primary choices, otherwise row by parity, column by 3/4 field
    function automatic logic [IO_W-1:0] uart_addr(input logic [1:0] sel,
                                                  input logic [1:0] col);
        logic [IO_W-1:0] a;
        if (sel == 2'd0)      a = 16'h03F8;
        else if (sel == 2'd1) a = 16'h02F8;
        else begin
            case ({sel[0], col})
                3'b000:  a = 16'h03E8;
                3'b001:  a = 16'h0338;
                3'b010:  a = 16'h02E8;
                3'b011:  a = 16'h0220;
                3'b100:  a = 16'h02E8;
                3'b101:  a = 16'h0238;
                3'b110:  a = 16'h02E0;
                default: a = 16'h0228;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] ID_BYTE = 8'h88
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic               acc_wr,
    input  logic               acc_rd,
    input  logic               acc_odd,
    input  logic [7:0]         wdata,
    output cfg_regs_t          regs,
    output logic [7:0]         cur_idx,
    output logic [7:0]         rdata,
    output logic               wr_pulse
);

    localparam logic [7:0] IDX_LIMIT = 8'(NUM_REGS);

    typedef struct packed {
        cfg_regs_t  regs;
        logic [7:0] idx;
        logic       id_pend;
        logic [7:0] rdata;
        logic       wr_pulse;
    } state_t;

    state_t st_d, st_q;
    logic   idx_ok;
    logic [7:0] sel_val;

    always_comb begin
        idx_ok = (st_q.idx < IDX_LIMIT);
        case (st_q.idx)
            8'd0:    sel_val = st_q.regs.en;
            8'd1:    sel_val = st_q.regs.map;
            8'd2:    sel_val = st_q.regs.pwr;
            default: sel_val = 8'h00;
        endcase
    end

    always_comb begin
        st_d          = st_q;
        st_d.wr_pulse = 1'b0;
        if (!rst_n) begin
            st_d.regs    = strap_defaults(strap);
            st_d.idx     = 8'h00;
            st_d.id_pend = 1'b1;
            st_d.rdata   = 8'h00;
        end else if (acc_wr) begin
            if (!acc_odd) begin
                st_d.idx     = wdata;
                st_d.id_pend = 1'b0;
            end else if (idx_ok) begin
                st_d.wr_pulse = 1'b1;
                case (st_q.idx)
                    8'd0:    st_d.regs.en  = wdata;
                    8'd1:    st_d.regs.map = wdata;
                    default: st_d.regs.pwr = wdata;
                endcase
            end
        end else if (acc_rd) begin
            if (!acc_odd) begin
                st_d.rdata   = st_q.id_pend ? ID_BYTE : st_q.idx;
                st_d.id_pend = 1'b0;
            end else begin
                st_d.rdata = sel_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs     = st_q.regs;
    assign cur_idx  = st_q.idx;
    assign rdata    = st_q.rdata;
    assign wr_pulse = st_q.wr_pulse;

endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
    import sio_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap,
    input  cfg_regs_t          regs,
    output dec_t               dec
);

    cfg_regs_t src;
    dec_t      dec_d, dec_q;
    logic [NUM_UART*IO_W-1:0]  u_base;
    logic [NUM_UART*IRQ_W-1:0] u_irq;
    logic [NUM_UART-1:0]       u_en;

    // while in reset, decode the defaults that the register file is loading
    assign src = rst_n ? regs : strap_defaults(strap);

    for (genvar u = 0; u < NUM_UART; u++) begin : g_uart
        logic [1:0] sel;
        assign sel = src.map[2*u+3:2*u+2];
        assign u_en[u] = src.en[u+1];
        assign u_base[u*IO_W +: IO_W]   = uart_addr(sel, src.map[7:6]);
        assign u_irq[u*IRQ_W +: IRQ_W]  = sel[0] ? IRQ_W'(3) : IRQ_W'(4);
    end

    always_comb begin
        dec_d = '0;
        dec_d.par_en = src.en[0];
        case (src.map[1:0])
            2'd0: begin
                dec_d.par_base = 16'h0378;
                dec_d.par_irq  = src.pwr[3] ? IRQ_W'(7) : IRQ_W'(5);
            end
            2'd1: begin
                dec_d.par_base = 16'h03BC;
                dec_d.par_irq  = IRQ_W'(7);
            end
            2'd2: begin
                dec_d.par_base = 16'h0278;
                dec_d.par_irq  = IRQ_W'(5);
            end
            default: begin
                dec_d.par_base = 16'h0000;
                dec_d.par_irq  = '0;
            end
        endcase
        dec_d.uart_en   = u_en;
        dec_d.uart_base = u_base;
        dec_d.uart_irq  = u_irq;
        dec_d.fdc_en    = src.en[3];
        dec_d.fdc_base  = src.en[5] ? 16'h0370 : 16'h03F0;
        dec_d.fdc_irq   = IRQ_W'(6);
        dec_d.ide_en    = src.en[6];
        dec_d.ide_base  = src.en[7] ? 16'h0170 : 16'h01F0;
        dec_d.ide_base2 = dec_d.ide_base + 16'h0206;
        dec_d.ide_irq   = IRQ_W'(14);
    end

    always_ff @(posedge clk) begin
        dec_q <= dec_d;
    end

    assign dec = dec_q;

endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
    import sio_cfg_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0398,
    parameter logic [7:0] ID_BYTE   = 8'h88
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [STRAP_W-1:0]        strap,
    input  logic [ADDR_W-1:0]         io_addr,
    input  logic                      io_byte,
    input  logic                      io_wr,
    input  logic                      io_rd,
    input  logic [7:0]                io_wdata,
    output logic [7:0]                io_rdata,
    output logic                      cfg_wr_pulse,
    output logic                      par_en,
    output logic [IO_W-1:0]           par_base,
    output logic [IRQ_W-1:0]          par_irq,
    output logic [NUM_UART-1:0]       uart_en,
    output logic [NUM_UART*IO_W-1:0]  uart_base,
    output logic [NUM_UART*IRQ_W-1:0] uart_irq,
    output logic                      fdc_en,
    output logic [IO_W-1:0]           fdc_base,
    output logic [IRQ_W-1:0]          fdc_irq,
    output logic                      ide_en,
    output logic [IO_W-1:0]           ide_base,
    output logic [IO_W-1:0]           ide_base2,
    output logic [IRQ_W-1:0]          ide_irq
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);

    logic       hit;
    logic       acc_wr, acc_rd;
    cfg_regs_t  regs;
    logic [7:0] cur_idx;
    dec_t       dec;

    assign hit    = io_byte && (io_addr[ADDR_W-1:1] == BASE_A[ADDR_W-1:1]);
    assign acc_wr = hit && io_wr;
    assign acc_rd = hit && io_rd;

    sio_cfg_regs #(.ID_BYTE(ID_BYTE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap    (strap),
        .acc_wr   (acc_wr),
        .acc_rd   (acc_rd),
        .acc_odd  (io_addr[0]),
        .wdata    (io_wdata),
        .regs     (regs),
        .cur_idx  (cur_idx),
        .rdata    (io_rdata),
        .wr_pulse (cfg_wr_pulse)
    );

    sio_cfg_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (strap),
        .regs  (regs),
        .dec   (dec)
    );

    assign par_en    = dec.par_en;
    assign par_base  = dec.par_base;
    assign par_irq   = dec.par_irq;
    assign uart_en   = dec.uart_en;
    assign uart_base = dec.uart_base;
    assign uart_irq  = dec.uart_irq;
    assign fdc_en    = dec.fdc_en;
    assign fdc_base  = dec.fdc_base;
    assign fdc_irq   = dec.fdc_irq;
    assign ide_en    = dec.ide_en;
    assign ide_base  = dec.ide_base;
    assign ide_base2 = dec.ide_base2;
    assign ide_irq   = dec.ide_irq;

endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0398
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_byte,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_rdata,
    input logic              cfg_wr_pulse,
    input logic [7:0]        cur_idx,
    input logic [15:0]       par_base,
    input logic [3:0]        par_irq,
    input logic [31:0]       uart_base,
    input logic [7:0]        uart_irq,
    input logic [15:0]       fdc_base,
    input logic [15:0]       ide_base,
    input logic [1:0]        uart_en,
    input logic              par_en
);

    logic data_hit;
    assign data_hit = io_byte && (io_addr == (ADDR_W'(BASE_ADDR) | ADDR_W'(1)));

    AST_PULSE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hit && io_wr && cur_idx < 8'd3) |=> cfg_wr_pulse); // R11

    AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_hit && io_wr && cur_idx < 8'd3) |=> !cfg_wr_pulse); // R11

    AST_BAD_IDX_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hit && io_rd && !io_wr && cur_idx >= 8'd3) |=> (io_rdata == 8'h00)); // R4

    AST_DECODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_pulse |=> ($stable(par_base) && $stable(uart_base) && $stable(fdc_base)
                           && $stable(ide_base) && $stable(uart_en) && $stable(par_en))); // R12

    AST_UART_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_irq[3:0] == 4'd3 || uart_irq[3:0] == 4'd4)
        && (uart_irq[7:4] == 4'd3 || uart_irq[7:4] == 4'd4)); // R9

    AST_PAR_NONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (par_base == 16'h0000) == (par_irq == 4'd0)); // R8

endmodule

bind sio_cfg_ctrl sio_cfg_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_addr      (io_addr),
    .io_byte      (io_byte),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_rdata     (io_rdata),
    .cfg_wr_pulse (cfg_wr_pulse),
    .cur_idx      (cur_idx),
    .par_base     (par_base),
    .par_irq      (par_irq),
    .uart_base    (uart_base),
    .uart_irq     (uart_irq),
    .fdc_base     (fdc_base),
    .ide_base     (ide_base),
    .uart_en      (uart_en),
    .par_en       (par_en)
);

// File: tb/sio_cfg_ctrl_bench.sv
`timescale 1ns/1ps
module sio_cfg_ctrl_bench;

    localparam logic [15:0] IDX_PORT  = 16'h0398;
    localparam logic [15:0] DATA_PORT = 16'h0399;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap = 5'd1;
    logic [15:0] io_addr = 16'h0;
    logic        io_byte = 1'b1;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        cfg_wr_pulse;
    logic        par_en, fdc_en, ide_en;
    logic [15:0] par_base, fdc_base, ide_base, ide_base2;
    logic [3:0]  par_irq, fdc_irq, ide_irq;
    logic [1:0]  uart_en;
    logic [31:0] uart_base;
    logic [7:0]  uart_irq;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    sio_cfg_ctrl u_sio_cfg_ctrl (
        .clk(clk), .rst_n(rst_n), .strap(strap), .io_addr(io_addr), .io_byte(io_byte),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_wr_pulse(cfg_wr_pulse), .par_en(par_en), .par_base(par_base), .par_irq(par_irq),
        .uart_en(uart_en), .uart_base(uart_base), .uart_irq(uart_irq),
        .fdc_en(fdc_en), .fdc_base(fdc_base), .fdc_irq(fdc_irq),
        .ide_en(ide_en), .ide_base(ide_base), .ide_base2(ide_base2), .ide_irq(ide_irq)
    );

    // ---------------- default tables (R1) ----------------
    byte unsigned t_en[32] = '{8'h4F,8'h4F,8'h4F,8'h4F,8'h4F,8'h4F,8'h4B,8'h4B,
                               8'h4B,8'h4B,8'h4B,8'h4B,8'h0F,8'h0F,8'h0F,8'h0F,
                               8'h49,8'h49,8'h49,8'h49,8'h07,8'h07,8'h07,8'h07,
                               8'h47,8'h47,8'h47,8'h47,8'h47,8'h47,8'h08,8'h00};
    byte unsigned t_map[32] = '{8'h10,8'h11,8'h11,8'h39,8'h24,8'h38,8'h00,8'h01,
                                8'h01,8'h09,8'h08,8'h08,8'h10,8'h11,8'h39,8'h24,
                                8'h00,8'h01,8'h01,8'h00,8'h10,8'h11,8'h39,8'h24,
                                8'h10,8'h11,8'h11,8'h39,8'h24,8'h38,8'h10,8'h10};
    int u_row0[4] = '{'h3E8, 'h338, 'h2E8, 'h220};
    int u_row1[4] = '{'h2E8, 'h238, 'h2E0, 'h228};

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_reg[3];
    int  m_src[3];
    int  m_idx, m_rd;
    bit  m_id, m_pulse, m_valid;

    always @(posedge clk) begin
        bit hit;
        hit = io_byte && (io_addr[15:1] == IDX_PORT[15:1]);
        if (!rst_n) begin
            m_reg[0] = t_en[strap]; m_reg[1] = t_map[strap];
            m_reg[2] = (strap == 31) ? 2 : 0;
            m_src = m_reg;
            m_idx = 0; m_id = 1; m_rd = 0; m_pulse = 0;
        end else begin
            m_src = m_reg;
            m_pulse = 0;
            if (hit && io_wr) begin
                if (io_addr[0] == 0) begin m_idx = io_wdata; m_id = 0; end
                else if (m_idx < 3) begin m_reg[m_idx] = io_wdata; m_pulse = 1; end
            end else if (hit && io_rd) begin
                if (io_addr[0] == 0) begin m_rd = m_id ? 'h88 : m_idx; m_id = 0; end
                else m_rd = (m_idx < 3) ? m_reg[m_idx] : 0;
            end
        end
        m_valid = 1;
    end

    function automatic int exp_uart_base(int s, int col);
        if (s == 0) return 'h3F8;
        if (s == 1) return 'h2F8;
        return (s % 2) ? u_row1[col] : u_row0[col];
    endfunction

    always @(negedge clk) begin
        if (m_valid) begin
            int en, mp, pw, pb, pi;
            en = m_src[0]; mp = m_src[1]; pw = m_src[2];
            check("R4 rdata", io_rdata, m_rd);
            check("R11 pulse", cfg_wr_pulse, m_pulse);
            check("R7 par_en", par_en, en % 2);
            check("R7 uart_en", uart_en, (en / 2) % 4);
            check("R7 fdc_en", fdc_en, (en / 8) % 2);
            check("R7 ide_en", ide_en, (en / 64) % 2);
            case (mp % 4)
                0: begin pb = 'h378; pi = ((pw / 8) % 2) ? 7 : 5; end
                1: begin pb = 'h3BC; pi = 7; end
                2: begin pb = 'h278; pi = 5; end
                default: begin pb = 0; pi = 0; end
            endcase
            check("R8 par_base", par_base, pb);
            check("R8 par_irq", par_irq, pi);
            for (int n = 0; n < 2; n++) begin
                int s;
                s = (mp / (4 << (2 * n))) % 4;
                check("R9 uart_base", (uart_base >> (16 * n)) & 'hFFFF, exp_uart_base(s, mp / 64));
                check("R9 uart_irq", (uart_irq >> (4 * n)) & 'hF, (s % 2) ? 3 : 4);
            end
            check("R10 fdc_base", fdc_base, ((en / 32) % 2) ? 'h370 : 'h3F0);
            check("R10 fdc_irq", fdc_irq, 6);
            check("R10 ide_base", ide_base, (en >= 128) ? 'h170 : 'h1F0);
            check("R10 ide_base2", ide_base2, ((en >= 128) ? 'h170 : 'h1F0) + 'h206);
            check("R10 ide_irq", ide_irq, 14);
        end
    end

    // ---------------- bus tasks (start and end at a falling edge) ----------------
    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input logic byt = 1'b1);
        io_addr = a; io_wdata = d; io_byte = byt; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_byte = 1'b1;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic do_reset(input logic [4:0] s);
        strap = s; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rd_reg(input int i, output logic [7:0] d);
        bus_wr(IDX_PORT, 8'(i));
        bus_rd(DATA_PORT, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        @(negedge clk);
        do_reset(5'd1);
        check("R1 rdata reset", io_rdata, 0);
        check("R1 pulse reset", cfg_wr_pulse, 0);
        bus_rd(IDX_PORT, d);  check("R5 id byte", d, 'h88);
        bus_rd(IDX_PORT, d);  check("R5 index after id", d, 0);
        bus_rd(DATA_PORT, d); check("R1 strap1 en", d, 'h4F);
        rd_reg(1, d);         check("R1 strap1 map", d, 'h11);
        rd_reg(2, d);         check("R1 strap1 pwr", d, 'h00);

        // index write ends ID phase
        do_reset(5'd1);
        bus_wr(IDX_PORT, 8'h02);
        bus_rd(IDX_PORT, d);  check("R5 id ended by write", d, 2);
        bus_wr(IDX_PORT, 8'hA7);
        bus_rd(IDX_PORT, d);  check("R2 index load", d, 'hA7);

        // index >= 3: writes ignored, reads zero
        bus_wr(DATA_PORT, 8'h77);
        check("R3 no pulse on bad idx", cfg_wr_pulse, 0);
        bus_rd(DATA_PORT, d); check("R4 bad idx read", d, 0);
        rd_reg(0, d); check("R3 en untouched", d, 'h4F);
        rd_reg(1, d); check("R3 map untouched", d, 'h11);
        rd_reg(2, d); check("R3 pwr untouched", d, 'h00);

        // wrong address and wrong width ignored
        bus_wr(16'h039A, 8'h01);
        bus_wr(DATA_PORT, 8'h33, 1'b0);
        check("R6 no pulse", cfg_wr_pulse, 0);
        bus_rd(IDX_PORT, d); check("R6 index kept", d, 2);
        bus_rd(DATA_PORT, d); check("R6 pwr kept", d, 0);

        // pulse and decode latency
        bus_wr(IDX_PORT, 8'h00);
        bus_wr(DATA_PORT, 8'h4E);
        check("R11 pulse high", cfg_wr_pulse, 1);
        check("R12 old par_en", par_en, 1);
        @(negedge clk);
        check("R11 pulse low", cfg_wr_pulse, 0);
        check("R12 new par_en", par_en, 0);
        rd_reg(0, d); check("R3 en written", d, 'h4E);

        // map sweep with power bit3 clear and set
        for (int p = 0; p < 2; p++) begin
            bus_wr(IDX_PORT, 8'h02);
            bus_wr(DATA_PORT, p ? 8'h08 : 8'h00);
            bus_wr(IDX_PORT, 8'h01);
            for (int v = 0; v < 256; v++) begin
                bus_wr(DATA_PORT, 8'(v));
                @(negedge clk);
            end
        end
        // enable sweep
        bus_wr(IDX_PORT, 8'h00);
        for (int v = 0; v < 256; v++) begin
            bus_wr(DATA_PORT, 8'(v));
            @(negedge clk);
        end

        // every strap
        for (int s = 0; s < 32; s++) begin
            do_reset(5'(s));
            rd_reg(0, d); check("R1 strap en", d, t_en[s]);
            rd_reg(1, d); check("R1 strap map", d, t_map[s]);
            rd_reg(2, d); check("R1 strap pwr", d, (s == 31) ? 2 : 0);
        end
        do_reset(5'd31);
        bus_rd(IDX_PORT, d); check("R5 id after strap31", d, 'h88);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule